// File: doc/BRIEF.md
# Bounded Jump Table Dispatcher

This block carries out the table lookup step of a multi-way branch. The issuing pipeline hands it four things: the value of an index register, a 16-bit upper bound, a 2-bit code for the entry width, and the address of the branch instruction. The block checks the index against both ends of the range in a single step. It picks either the indexed slot or a default slot, and it sends one read to instruction memory for that slot. When the read returns, it turns the returned entry into an absolute branch target.

The table sits in the instruction stream. It begins at the word right after the branch. It holds signed displacements that are counted in 4-byte units from the start of the table, so code that contains such a table can be loaded at any address. The default entry is placed directly after the last case entry. Only one lookup is in flight at a time. While a lookup is in flight the block reports busy and ignores new requests.

Top module: `jump_table_dispatch`

## Requirements
- R1: After reset, busy, mem_rd_valid and tgt_valid are all 0.
- R2: A request whose index, read as a signed number, lies in 0..max (both ends included) reads slot number equal to the index.
- R3: A request whose index is negative (top bit set) reads the default slot, which is slot max+1.
- R4: A request whose index is greater than max reads the default slot max+1. This holds for max = 65535 as well, where the default slot is 65536.
- R5: The read address is pc + 4 + slot × 2^size. The size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes, and mem_rd_size repeats the request's code.
- R6: mem_rd_valid is high for exactly one cycle, the cycle after the request is accepted.
- R7: The entry is taken from the low 8, 16, 32 or 64 bits of mem_rsp_data, chosen by the size code, and is sign-extended from that width. The bits above the entry have no effect.
- R8: The target equals pc + 4 plus the sign-extended entry shifted left by 2.
- R9: tgt_valid is a one-cycle pulse, high in the cycle after the accepted response, with tgt_addr valid in that cycle.
- R10: busy is high from the cycle after acceptance through the tgt_valid cycle, and then drops. A request made while busy is high starts no read and does not change the pending lookup.
- R11: A response that arrives while no read is outstanding produces no tgt_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a lookup; accepted when busy is low |
| req_index | input | IDX_W | Index register value, signed |
| req_max | input | MAX_W | Largest valid case index |
| req_size | input | 2 | Entry width code |
| req_pc | input | ADDR_W | Address of the branch instruction |
| busy | output | 1 | A lookup is in progress |
| mem_rd_valid | output | 1 | Table entry read request |
| mem_rd_addr | output | ADDR_W | Byte address of the entry |
| mem_rd_size | output | 2 | Entry width code of the read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | ENTRY_W | Read data, entry in the low bits |
| tgt_valid | output | 1 | Branch target is valid |
| tgt_addr | output | ADDR_W | Computed branch target |

## Verification
The hardest cases to reach are the two ends of the 16-bit bound. At max = 65535, an index just above the bound needs a seventeenth slot bit. At max = 65534, the last legal index must still read its own slot and not the default slot. The vector table drives both of these directly, together with a very negative 64-bit index. The vectors also place random-looking data above each entry so that a sign extension from the wrong width changes the target. Requests made during a pending read, and responses that arrive while the block is idle, are driven inside the lookup sequence at set cycles.

// File: rtl/jtd_pkg.sv
package jtd_pkg;

    localparam int ENTRY_W = 64;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } esize_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } state_e;

    // Sign-extend the entry held in the low bits of a fetched word.
    function automatic logic [ENTRY_W-1:0] sext_entry(
        input logic [ENTRY_W-1:0] raw,
        input esize_e             sz
    );
        logic [ENTRY_W-1:0] r;
        case (sz)
            SZ_BYTE:  r = ENTRY_W'($signed(raw[7:0]));
            SZ_HALF:  r = ENTRY_W'($signed(raw[15:0]));
            SZ_WORD:  r = ENTRY_W'($signed(raw[31:0]));
            default:  r = raw;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/jtd_bounds.sv
module jtd_bounds #(
    parameter int IDX_W  = 64,
    parameter int MAX_W  = 16,
    parameter int SLOT_W = MAX_W + 1
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [MAX_W-1:0]  maxv,
    output logic [SLOT_W-1:0] slot
);
    logic below_zero;
    logic above_max;

    always_comb begin
        below_zero = idx[IDX_W-1];
        above_max  = idx > IDX_W'(maxv);
        if (below_zero || above_max)
            slot = SLOT_W'(maxv) + SLOT_W'(1);
        else
            slot = idx[SLOT_W-1:0];
    end
endmodule

// File: rtl/jtd_addr.sv
module jtd_addr #(
    parameter int ADDR_W = 64,
    parameter int SLOT_W = 17
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [SLOT_W-1:0] slot,
    input  jtd_pkg::esize_e   sz,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = base + (ADDR_W'(slot) << sz);
    end
endmodule

// File: rtl/jtd_target.sv
module jtd_target #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0]           base,
    input  logic [jtd_pkg::ENTRY_W-1:0] raw,
    input  jtd_pkg::esize_e             sz,
    output logic [ADDR_W-1:0]           target
);
    logic [jtd_pkg::ENTRY_W-1:0] disp;

    always_comb begin
        disp   = jtd_pkg::sext_entry(raw, sz);
        target = base + (ADDR_W'(disp) << 2);
    end
endmodule

// File: rtl/jump_table_dispatch.sv
module jump_table_dispatch #(
    parameter int IDX_W   = 64,
    parameter int MAX_W   = 16,
    parameter int ADDR_W  = 64,
    parameter int ENTRY_W = jtd_pkg::ENTRY_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [IDX_W-1:0]   req_index,
    input  logic [MAX_W-1:0]   req_max,
    input  logic [1:0]         req_size,
    input  logic [ADDR_W-1:0]  req_pc,
    output logic               busy,
    output logic               mem_rd_valid,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    output logic [1:0]         mem_rd_size,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               tgt_valid,
    output logic [ADDR_W-1:0]  tgt_addr
);
    import jtd_pkg::*;

    localparam int SLOT_W = MAX_W + 1;

    state_e            state_q;
    logic [ADDR_W-1:0] table_base;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] addr_d;
    logic [ADDR_W-1:0] addr_q;
    esize_e            size_q;
    logic [SLOT_W-1:0] slot;
    logic [ADDR_W-1:0] target_d;
    logic [ADDR_W-1:0] target_q;
    logic              accept;
    logic              rsp_take;

    assign table_base = req_pc + ADDR_W'(4);
    assign accept     = req_valid && (state_q == ST_IDLE);
    assign rsp_take   = mem_rsp_valid && (state_q == ST_WAIT);

    jtd_bounds #(.IDX_W(IDX_W), .MAX_W(MAX_W), .SLOT_W(SLOT_W)) u_bounds (
        .idx  (req_index),
        .maxv (req_max),
        .slot (slot)
    );

    jtd_addr #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_addr (
        .base (table_base),
        .slot (slot),
        .sz   (esize_e'(req_size)),
        .addr (addr_d)
    );

    jtd_target #(.ADDR_W(ADDR_W)) u_target (
        .base   (base_q),
        .raw    (mem_rsp_data),
        .sz     (size_q),
        .target (target_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            base_q   <= '0;
            addr_q   <= '0;
            size_q   <= SZ_BYTE;
            target_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    base_q  <= table_base;
                    addr_q  <= addr_d;
                    size_q  <= esize_e'(req_size);
                    state_q <= ST_ISSUE;
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: if (rsp_take) begin
                    target_q <= target_d;
                    state_q  <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state_q != ST_IDLE);
    assign mem_rd_valid = (state_q == ST_ISSUE);
    assign mem_rd_addr  = addr_q;
    assign mem_rd_size  = size_q;
    assign tgt_valid    = (state_q == ST_DONE);
    assign tgt_addr     = target_q;
endmodule

// File: rtl/jtd_checker.sv
module jtd_checker (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic mem_rd_valid,
    input logic tgt_valid
);
    // R6
    a_r6_read_single: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |=> !mem_rd_valid);
    // R9
    a_r9_target_pulse: assert property (@(posedge clk) disable iff (rst)
        tgt_valid |=> !tgt_valid);
    // R10
    a_r10_read_while_busy: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> busy);
    // R10
    a_r10_accept_issues: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (mem_rd_valid && busy));
    // R10
    a_r10_release: assert property (@(posedge clk) disable iff (rst)
        tgt_valid |=> !busy);
    // R9, R10
    a_r10_target_busy: assert property (@(posedge clk) disable iff (rst)
        tgt_valid |-> busy);
endmodule

bind jump_table_dispatch jtd_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .busy         (busy),
    .mem_rd_valid (mem_rd_valid),
    .tgt_valid    (tgt_valid)
);

// File: tb/jump_table_dispatch_test.sv
module jump_table_dispatch_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_index;
    logic [15:0] req_max;
    logic [1:0]  req_size;
    logic [63:0] req_pc;
    logic        busy;
    logic        mem_rd_valid;
    logic [63:0] mem_rd_addr;
    logic [1:0]  mem_rd_size;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        tgt_valid;
    logic [63:0] tgt_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    jump_table_dispatch uut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_index     (req_index),
        .req_max       (req_max),
        .req_size      (req_size),
        .req_pc        (req_pc),
        .busy          (busy),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_size   (mem_rd_size),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .tgt_valid     (tgt_valid),
        .tgt_addr      (tgt_addr)
    );

    typedef struct packed {
        logic [63:0] idx;
        logic [15:0] mx;
        logic [1:0]  sz;
        logic [63:0] pc;
        logic [63:0] data;
        logic [16:0] slot;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{64'd3, 16'd10, 2'd2, 64'h1000, 64'hFFFF_0000_0000_0010, 17'd3},
        '{64'hFFFF_FFFF_FFFF_FFFF, 16'd5, 2'd0, 64'h2000, 64'h0000_0000_0000_ABFE, 17'd6},
        '{64'd9, 16'd8, 2'd1, 64'h3000, 64'h1234_5678_9ABC_8000, 17'd9},
        '{64'd0, 16'd0, 2'd3, 64'h4000, 64'h0000_0000_0000_0100, 17'd0},
        '{64'd65534, 16'd65534, 2'd3, 64'h10000, 64'hFFFF_FFFF_FFFF_FFF0, 17'd65534},
        '{64'd65535, 16'd65534, 2'd2, 64'h20000, 64'hDEAD_BEEF_8000_0001, 17'd65535},
        '{64'h8000_0000_0000_0000, 16'd100, 2'd1, 64'h5000, 64'h0000_0000_0000_7FFF, 17'd101},
        '{64'h0000_0000_0001_0000, 16'd65535, 2'd0, 64'h6000, 64'h0000_0000_0000_0080, 17'd65536}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ext(input logic [63:0] d, input logic [1:0] sz);
        case (sz)
            2'd0:    return {{56{d[7]}}, d[7:0]};
            2'd1:    return {{48{d[15]}}, d[15:0]};
            2'd2:    return {{32{d[31]}}, d[31:0]};
            default: return d;
        endcase
    endfunction

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // One full lookup; optional disturbance with a request while busy (R10).
    task automatic lookup(input vec_t v, input bit poke);
        logic [63:0] base;
        base = v.pc + 64'd4;
        req_valid = 1'b1;
        req_index = v.idx;
        req_max   = v.mx;
        req_size  = v.sz;
        req_pc    = v.pc;
        @(posedge clk); @(negedge clk);
        req_valid = poke;
        req_index = 64'd1;
        req_max   = 16'd7;
        req_size  = 2'd0;
        req_pc    = 64'hF000;
        check("R6 read pulse", 64'(mem_rd_valid), 64'd1);
        check("R10 busy", 64'(busy), 64'd1);
        check("R2 R3 R4 R5 address", mem_rd_addr, base + (64'(v.slot) << v.sz));
        check("R5 size", 64'(mem_rd_size), 64'(v.sz));
        @(posedge clk); @(negedge clk);
        check("R6 read ends", 64'(mem_rd_valid), 64'd0);
        req_valid     = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = v.data;
        @(posedge clk); @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 64'hFFFF_FFFF_FFFF_FFFF;
        check("R9 target valid", 64'(tgt_valid), 64'd1);
        check("R7 R8 target", tgt_addr, base + (ext(v.data, v.sz) << 2));
        check("R10 busy at target", 64'(busy), 64'd1);
        @(posedge clk); @(negedge clk);
        check("R9 target pulse ends", 64'(tgt_valid), 64'd0);
        check("R10 idle", 64'(busy), 64'd0);
        check("R10 no extra read", 64'(mem_rd_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_index = '0;
        req_max = '0;
        req_size = '0;
        req_pc = '0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 read", 64'(mem_rd_valid), 64'd0);
        check("R1 target", 64'(tgt_valid), 64'd0);

        for (int i = 0; i < NV; i++) lookup(VECS[i], 1'b0);

        // R10: request held high while busy must not alter the pending lookup
        lookup(VECS[2], 1'b1);

        // R11: stray response while idle
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 64'h55;
        @(posedge clk); @(negedge clk);
        mem_rsp_valid = 1'b0;
        check("R11 stray response", 64'(tgt_valid), 64'd0);
        @(posedge clk); @(negedge clk);
        check("R11 still idle", 64'(tgt_valid), 64'd0);
        check("R11 not busy", 64'(busy), 64'd0);

        // R1: reset in the middle of a lookup
        req_valid = 1'b1;
        req_index = 64'd2;
        req_max = 16'd4;
        req_size = 2'd1;
        req_pc = 64'h700;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1 busy after reset", 64'(busy), 64'd0);
        check("R1 read after reset", 64'(mem_rd_valid), 64'd0);

        report();
    end
endmodule